// File: doc/BRIEF.md
# Predicated Vector Integer Comparator

This unit compares two 256-bit vectors element by element and writes a predicate that has one bit for each byte of the vector. The element width is a byte, halfword, word or doubleword, chosen by a 2-bit size code. The result bit for each element is placed at the predicate position of that element's lowest byte. The other bits that belong to the element read zero. A governing predicate selects which elements take part, and an element that is not selected yields 0.

There are two operand forms. In the same-size form, each element of the first vector is compared with the element of the second vector at the same position. In the wide form, the second vector is read as four 64-bit values. Each narrow element of the first vector is compared with the 64-bit value that lies in its own 64-bit chunk. Together with the result, the unit produces the four condition flags of a predicate test on that result.

Results are registered. They change only on a clock edge where the valid strobe is high and the request is legal. An illegal request raises a sticky-until-next-strobe illegal flag and leaves the result and the flags untouched.

Top module: `vec_pred_cmp`

## Requirements
- R1: Predicate bit k stands for vector byte k. For size code 0/1/2/3 (byte/half/word/dword), the element occupying bytes [k, k+2^size) puts its result at bit k, where k is a multiple of 2^size. Every other bit of that element is 0.
- R2: A result bit is the compare outcome ANDed with the governing predicate bit at the element's lowest byte. A zero governing bit gives 0, whatever the data.
- R3: Same-size mode (wide_i=0) accepts condition codes 0 equal, 1 not equal, 2 signed greater, 3 signed greater-or-equal, 4 unsigned higher and 5 unsigned higher-or-same. The elements are compared at their own width.
- R4: Wide mode (wide_i=1) accepts codes 0..5 as above, plus 6 signed less, 7 signed less-or-equal, 8 unsigned lower and 9 unsigned lower-or-same. The second operand is the 64-bit value vec_b_i[64c+63:64c] of the chunk c holding the element.
- R5: In wide mode the narrow element is sign-extended to 64 bits for codes 2, 3, 6 and 7, and zero-extended for all other codes.
- R6: A strobe is illegal when it combines wide mode with size 3, or when its condition code lies outside the set accepted by its mode. An illegal strobe sets illegal_o to 1 and leaves pred_o and nzcv_o unchanged. A legal strobe clears illegal_o.
- R7: pred_o, nzcv_o and illegal_o change only at a rising edge with valid_i high. The new value is visible after that edge. Without valid_i, changes on any input have no effect on the outputs.
- R8: nzcv_o = {N,Z,C,V}. Let the active bits be the governing bits at element-start positions. N is the result at the lowest active bit. Z is 1 when no result bit is set. C is the inverse of the result at the highest active bit, and is 1 when no bit is active. V is 0.
- R9: After reset, pred_o = 0, nzcv_o = 4'b0110 and illegal_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Strobe that captures a compare |
| size_i | input | 2 | Element size code: 0 byte, 1 half, 2 word, 3 dword |
| cond_i | input | 4 | Condition code (see R3, R4) |
| wide_i | input | 1 | 1 selects the wide second-operand form |
| vec_a_i | input | 256 | First vector operand |
| vec_b_i | input | 256 | Second vector operand |
| gov_i | input | 32 | Governing predicate, one bit per byte |
| pred_o | output | 32 | Registered result predicate |
| nzcv_o | output | 4 | Registered predicate-test flags {N,Z,C,V} |
| illegal_o | output | 1 | Last strobe was an illegal combination |

## Verification
The assertions check the following on every cycle:
- The outputs hold when there is no strobe.
- An illegal strobe freezes the result and flags and raises illegal_o, and a legal strobe clears it.
- No bit outside the active element starts is set after an update.
- The Z and N flags agree with the stored predicate.

Only the bench's scenarios can show the following:
- That each condition code computes the right signed or unsigned relation at each width.
- That the wide form picks the correct 64-bit chunk and extension.
- That N and C track the lowest and highest active lanes.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  typedef enum logic [3:0] {
    CMP_EQ = 4'd0,
    CMP_NE = 4'd1,
    CMP_GT = 4'd2,
    CMP_GE = 4'd3,
    CMP_HI = 4'd4,
    CMP_HS = 4'd5,
    CMP_LT = 4'd6,
    CMP_LE = 4'd7,
    CMP_LO = 4'd8,
    CMP_LS = 4'd9
  } cmp_cond_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DWORD = 2'd3
  } elem_size_e;

  localparam logic [3:0] LAST_SAME_COND = 4'd5;
  localparam logic [3:0] LAST_WIDE_COND = 4'd9;

  // Conditions that interpret operands as two's complement.
  function automatic logic cond_is_signed(input logic [3:0] cond);
    return (cond == CMP_GT) || (cond == CMP_GE) ||
           (cond == CMP_LT) || (cond == CMP_LE);
  endfunction

  // Extend a narrow element held in the low bits of raw to 64 bits.
  function automatic logic [63:0] lane_ext(input logic [63:0] raw,
                                           input logic [1:0]  sz,
                                           input logic        sx);
    logic [63:0] r;
    case (sz)
      SZ_BYTE: r = {{56{sx & raw[7]}},  raw[7:0]};
      SZ_HALF: r = {{48{sx & raw[15]}}, raw[15:0]};
      SZ_WORD: r = {{32{sx & raw[31]}}, raw[31:0]};
      default: r = raw;
    endcase
    return r;
  endfunction

  // Evaluate one condition on two already-extended 64-bit operands.
  function automatic logic lane_eval(input logic [3:0]  cond,
                                     input logic [63:0] x,
                                     input logic [63:0] y);
    logic r;
    case (cond)
      CMP_EQ: r = (x == y);
      CMP_NE: r = (x != y);
      CMP_GT: r = ($signed(x) >  $signed(y));
      CMP_GE: r = ($signed(x) >= $signed(y));
      CMP_HI: r = (x >  y);
      CMP_HS: r = (x >= y);
      CMP_LT: r = ($signed(x) <  $signed(y));
      CMP_LE: r = ($signed(x) <= $signed(y));
      CMP_LO: r = (x <  y);
      CMP_LS: r = (x <= y);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // Legal combination of mode, size and condition code.
  function automatic logic combo_legal(input logic       wide,
                                       input logic [1:0] sz,
                                       input logic [3:0] cond);
    logic ok;
    if (wide) ok = (sz != SZ_DWORD) && (cond <= LAST_WIDE_COND);
    else      ok = (cond <= LAST_SAME_COND);
    return ok;
  endfunction

endpackage

// File: rtl/vpc_lane_array.sv
module vpc_lane_array
  import vpc_pkg::*;
#(
  parameter int unsigned VEC_BITS = 256,
  localparam int unsigned PB = VEC_BITS / 8
) (
  input  logic [VEC_BITS-1:0] a_i,
  input  logic [VEC_BITS-1:0] b_i,
  input  logic [1:0]          sz_i,
  input  logic [3:0]          cond_i,
  input  logic                wide_i,
  output logic [PB-1:0]       hit_o
);

  logic [3:0][PB-1:0] hit_sz;
  logic               sx;

  assign sx = cond_is_signed(cond_i);

  for (genvar s = 0; s < 4; s++) begin : g_size
    localparam int unsigned EW  = 8 << s;
    localparam int unsigned BPE = 1 << s;
    localparam int unsigned NL  = VEC_BITS / EW;
    logic [PB-1:0] hits;

    for (genvar i = 0; i < NL; i++) begin : g_lane
      localparam int unsigned CHUNK = (i * EW) / 64;
      logic [63:0] a_raw, b_raw, a_x, b_x;
      assign a_raw = 64'(a_i[i*EW +: EW]);
      assign b_raw = 64'(b_i[i*EW +: EW]);
      assign a_x   = lane_ext(a_raw, 2'(s), sx);
      assign b_x   = wide_i ? b_i[CHUNK*64 +: 64] : lane_ext(b_raw, 2'(s), sx);
      assign hits[i*BPE] = lane_eval(cond_i, a_x, b_x);
      for (genvar j = 1; j < BPE; j++) begin : g_pad
        assign hits[i*BPE + j] = 1'b0;
      end
    end

    assign hit_sz[s] = hits;
  end

  assign hit_o = hit_sz[sz_i];

endmodule

// File: rtl/vpc_size_mask.sv
module vpc_size_mask #(
  parameter int unsigned PB = 32
) (
  input  logic [1:0]    sz_i,
  input  logic [PB-1:0] gov_i,
  output logic [PB-1:0] start_o,
  output logic [PB-1:0] active_o
);

  always_comb begin
    for (int k = 0; k < PB; k++) begin
      start_o[k] = ((k & ((1 << sz_i) - 1)) == 0);
    end
  end

  assign active_o = gov_i & start_o;

endmodule

// File: rtl/vpc_ptest.sv
module vpc_ptest #(
  parameter int unsigned PB = 32
) (
  input  logic [PB-1:0] d_i,
  input  logic [PB-1:0] g_i,
  output logic [3:0]    nzcv_o
);

  logic seen, first_d, last_d;

  always_comb begin
    seen    = 1'b0;
    first_d = 1'b0;
    last_d  = 1'b0;
    for (int k = 0; k < PB; k++) begin
      if (g_i[k]) begin
        if (!seen) first_d = d_i[k];
        seen   = 1'b1;
        last_d = d_i[k];
      end
    end
  end

  assign nzcv_o = {first_d, ~|(d_i & g_i), ~last_d, 1'b0};

endmodule

// File: rtl/vec_pred_cmp.sv
module vec_pred_cmp
  import vpc_pkg::*;
#(
  parameter int unsigned VEC_BITS = 256,
  localparam int unsigned PB = VEC_BITS / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid_i,
  input  logic [1:0]          size_i,
  input  logic [3:0]          cond_i,
  input  logic                wide_i,
  input  logic [VEC_BITS-1:0] vec_a_i,
  input  logic [VEC_BITS-1:0] vec_b_i,
  input  logic [PB-1:0]       gov_i,
  output logic [PB-1:0]       pred_o,
  output logic [3:0]          nzcv_o,
  output logic                illegal_o
);

  localparam logic [3:0] NZCV_EMPTY = 4'b0110;

  logic [PB-1:0] raw_hit, start_mask, act_mask, gated;
  logic [3:0]    nzcv_next;
  logic          legal, upd_fire, bad_fire;

  vpc_lane_array #(.VEC_BITS(VEC_BITS)) u_lanes (
    .a_i    (vec_a_i),
    .b_i    (vec_b_i),
    .sz_i   (size_i),
    .cond_i (cond_i),
    .wide_i (wide_i),
    .hit_o  (raw_hit)
  );

  vpc_size_mask #(.PB(PB)) u_mask (
    .sz_i     (size_i),
    .gov_i    (gov_i),
    .start_o  (start_mask),
    .active_o (act_mask)
  );

  assign gated = raw_hit & act_mask;

  vpc_ptest #(.PB(PB)) u_ptest (
    .d_i    (gated),
    .g_i    (act_mask),
    .nzcv_o (nzcv_next)
  );

  assign legal    = combo_legal(wide_i, size_i, cond_i);
  assign upd_fire = valid_i & legal;
  assign bad_fire = valid_i & ~legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_o    <= '0;
      nzcv_o    <= NZCV_EMPTY;
      illegal_o <= 1'b0;
    end else if (upd_fire) begin
      pred_o    <= gated;
      nzcv_o    <= nzcv_next;
      illegal_o <= 1'b0;
    end else if (bad_fire) begin
      illegal_o <= 1'b1;
    end
  end

endmodule

// File: rtl/vpc_chk.sv
module vpc_chk #(
  parameter int unsigned PB = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_i,
  input logic          upd_fire,
  input logic          bad_fire,
  input logic [PB-1:0] act_mask,
  input logic [PB-1:0] pred_o,
  input logic [3:0]    nzcv_o,
  input logic          illegal_o
);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(pred_o) && $stable(nzcv_o) && $stable(illegal_o));

  a_r6_bad_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fire |=> $stable(pred_o) && $stable(nzcv_o) && illegal_o);

  a_r6_good_clear: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> !illegal_o);

  a_r2_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> ((pred_o & ~$past(act_mask)) == '0));

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    nzcv_o[2] == (pred_o == '0));

  a_r8_neg_vs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    nzcv_o[3] |-> !nzcv_o[2]);

endmodule

bind vec_pred_cmp vpc_chk #(.PB(PB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .upd_fire  (upd_fire),
  .bad_fire  (bad_fire),
  .act_mask  (act_mask),
  .pred_o    (pred_o),
  .nzcv_o    (nzcv_o),
  .illegal_o (illegal_o)
);

// File: tb/sim_vec_pred_cmp.sv
module sim_vec_pred_cmp;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   size_i = '0;
  logic [3:0]   cond_i = '0;
  logic         wide_i = 1'b0;
  logic [255:0] vec_a_i = '0;
  logic [255:0] vec_b_i = '0;
  logic [31:0]  gov_i = '0;
  logic [31:0]  pred_o;
  logic [3:0]   nzcv_o;
  logic         illegal_o;

  int total = 0;
  int bad = 0;

  logic [31:0] exp_pred = '0;
  logic [3:0]  exp_f = 4'b0110;
  logic        exp_ill = 1'b0;

  always #10 clk = ~clk;

  vec_pred_cmp u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .size_i(size_i),
    .cond_i(cond_i), .wide_i(wide_i), .vec_a_i(vec_a_i), .vec_b_i(vec_b_i),
    .gov_i(gov_i), .pred_o(pred_o), .nzcv_o(nzcv_o), .illegal_o(illegal_o)
  );

  function automatic logic is_sgn(logic [3:0] c);
    return c == 4'd2 || c == 4'd3 || c == 4'd6 || c == 4'd7;
  endfunction

  function automatic logic ok_combo(logic w, logic [1:0] s, logic [3:0] c);
    if (w) return (s != 2'd3) && (c <= 4'd9);
    return c <= 4'd5;
  endfunction

  function automatic logic [31:0] ref_pred(logic [255:0] a, logic [255:0] b,
      logic [31:0] g, logic [1:0] sz, logic [3:0] c, logic w);
    logic [31:0] r = '0;
    int bpe = 1 << sz;
    int ew = 8 * bpe;
    logic [63:0] msk = (ew == 64) ? {64{1'b1}} : ((64'd1 << ew) - 64'd1);
    for (int e = 0; e < 32 / bpe; e++) begin
      int k = e * bpe;
      logic [255:0] ta = a >> (k * 8);
      logic [255:0] tb = w ? (b >> ((k / 8) * 64)) : (b >> (k * 8));
      logic [63:0] x = ta[63:0] & msk;
      logic [63:0] y = w ? tb[63:0] : (tb[63:0] & msk);
      logic o;
      if (is_sgn(c) && x[ew-1]) x = x | ~msk;
      if (!w && is_sgn(c) && y[ew-1]) y = y | ~msk;
      case (c)
        4'd0: o = x == y;
        4'd1: o = x != y;
        4'd2: o = $signed(x) > $signed(y);
        4'd3: o = $signed(x) >= $signed(y);
        4'd4: o = x > y;
        4'd5: o = x >= y;
        4'd6: o = $signed(x) < $signed(y);
        4'd7: o = $signed(x) <= $signed(y);
        4'd8: o = x < y;
        4'd9: o = x <= y;
        default: o = 1'b0;
      endcase
      r[k] = o & g[k];
    end
    return r;
  endfunction

  function automatic logic [3:0] ref_flags(logic [31:0] d, logic [31:0] g, logic [1:0] sz);
    int first = -1;
    int last = -1;
    for (int k = 0; k < 32; k += (1 << sz)) begin
      if (g[k]) begin
        if (first < 0) first = k;
        last = k;
      end
    end
    return {(first >= 0) ? d[first] : 1'b0, d == 0, (last >= 0) ? ~d[last] : 1'b1, 1'b0};
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, 64'(pred_o), 64'(exp_pred));
    chk({tag, "/R8 flags"}, 64'(nzcv_o), 64'(exp_f));
    chk({tag, "/R6 illegal"}, 64'(illegal_o), 64'(exp_ill));
  endtask

  task automatic do_op(logic [255:0] a, logic [255:0] b, logic [31:0] g,
                       logic [1:0] sz, logic [3:0] c, logic w, string tag);
    @(negedge clk);
    vec_a_i = a; vec_b_i = b; gov_i = g; size_i = sz; cond_i = c; wide_i = w;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    if (ok_combo(w, sz, c)) begin
      exp_pred = ref_pred(a, b, g, sz, c, w);
      exp_f = ref_flags(exp_pred, g, sz);
      exp_ill = 1'b0;
    end else begin
      exp_ill = 1'b1;
    end
    check_all(tag);
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] va, vb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 reset");

    va = rnd256();
    do_op(va, va, 32'hFFFF_FFFF, 2'd0, 4'd0, 1'b0, "R1 byte eq");
    chk("R1 byte eq literal", 64'(pred_o), 64'h0000_0000_FFFF_FFFF);
    do_op(va, va, 32'hFFFF_FFFF, 2'd1, 4'd0, 1'b0, "R1 half eq");
    chk("R1 half layout", 64'(pred_o), 64'h0000_0000_5555_5555);
    do_op(va, va, 32'hFFFF_FFFF, 2'd3, 4'd5, 1'b0, "R1 dword hs");
    chk("R1 dword layout", 64'(pred_o), 64'h0000_0000_0101_0101);
    do_op(va, va, 32'h0, 2'd0, 4'd0, 1'b0, "R2 no active");
    chk("R2 empty flags", 64'(nzcv_o), 64'h6);
    do_op(va, va, 32'hF0F0_0F0F, 2'd0, 4'd0, 1'b0, "R2 partial gov");

    do_op({16{16'h8000}}, {16{16'h0001}}, 32'hFFFF_FFFF, 2'd1, 4'd2, 1'b0, "R3 signed gt");
    chk("R3 signed gt literal", 64'(pred_o), 64'h0);
    do_op({16{16'h8000}}, {16{16'h0001}}, 32'hFFFF_FFFF, 2'd1, 4'd4, 1'b0, "R3 unsigned hi");
    chk("R3 unsigned hi literal", 64'(pred_o), 64'h5555_5555);

    va = {32{8'hFF}};
    vb = {64'd1, 64'h0000_0000_0000_00FF, 64'd0, {64{1'b1}}};
    do_op(va, vb, 32'hFFFF_FFFF, 2'd0, 4'd0, 1'b1, "R5 wide eq zero-extend");
    chk("R4 wide eq literal", 64'(pred_o), 64'h00FF_0000);
    do_op(va, vb, 32'hFFFF_FFFF, 2'd0, 4'd6, 1'b1, "R5 wide lt sign-extend");
    do_op(va, vb, 32'hFFFF_FFFF, 2'd0, 4'd8, 1'b1, "R4 wide lo");
    do_op(va, vb, 32'hFFFF_FFFF, 2'd2, 4'd7, 1'b1, "R4 wide le word");

    do_op(rnd256(), rnd256(), 32'hFFFF_FFFF, 2'd3, 4'd0, 1'b1, "R6 wide dword");
    do_op(rnd256(), rnd256(), 32'hFFFF_FFFF, 2'd0, 4'd7, 1'b0, "R6 same-size cond7");
    do_op(rnd256(), rnd256(), 32'hFFFF_FFFF, 2'd1, 4'd12, 1'b1, "R6 cond12");
    do_op(va, va, 32'hFFFF_FFFF, 2'd0, 4'd1, 1'b0, "R6 legal clears");

    for (int n = 0; n < 400; n++) begin
      logic [255:0] ra = rnd256();
      logic [255:0] rb = (($urandom % 2) == 0) ? (ra ^ (rnd256() & rnd256() & rnd256() & rnd256())) : rnd256();
      logic [31:0] rg = (($urandom % 4) == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
      do_op(ra, rb, rg, 2'($urandom), 4'($urandom % 12), 1'($urandom), "R3/R4/R8 random");
      if ((n % 50) == 0) begin
        @(negedge clk);
        vec_a_i = rnd256(); gov_i = $urandom; cond_i = 4'($urandom);
        @(negedge clk);
        check_all("R7 idle hold");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule